// File: doc/BRIEF.md
# Balanced Ternary Accumulator Adder

This block adds or subtracts a balanced ternary operand into an accumulator. Every trit of a word is carried on two wires: `10` is minus one, `00` is zero and `01` is plus one. The first operand is always the accumulator register. The second comes from a bus input. The sum is formed by a ripple of digit cells. Each cell folds its local total, which lies in -3..+3, into one balanced digit and a carry of -1, 0 or +1.

A subtract request negates the bus operand before the add. It does this by swapping the two wires of every trit, so no complement-and-increment step is needed. The sum word, the carry out of the top trit and a zero flag are all combinational. When the enable is high, the sum word is written into the accumulator on the clock edge. The word width in trits is a parameter, and the default of five trits spans -121..+121.

Top module: `bct_acc_adder`

## Requirements
- R1: A trit is encoded as two bits, with `10` = -1, `00` = 0 and `01` = +1. Trit k of a word sits in bits [2k+1:2k], and trit 0 is the least significant with weight 1.
- R2: With `sub_i` low, `sum_o` holds the value of `acc_o` + `bus_i`, folded into the balanced range of W trits (modulo 3^W).
- R3: With `sub_i` high, `sum_o` holds the value of `acc_o` - `bus_i`, folded the same way.
- R4: `carry_o` is the trit that the top digit sends out: +1 when the exact result exceeds (3^W-1)/2, -1 when it is below -(3^W-1)/2, and 0 otherwise. Whenever it is non-zero, `sum_o` is non-zero.
- R5: `zero_o` is high exactly when every trit of `sum_o` is `00`.
- R6: On a rising clock edge with `en_i` high, `acc_o` takes the value of `sum_o`, and the carry trit is dropped. With `en_i` low, `acc_o` holds its value.
- R7: While `rst_ni` is low, `acc_o` is all zero trits. The clear is asynchronous.
- R8: No trit of `sum_o` or `acc_o`, and not `carry_o`, ever shows the unused code `11`, as long as `bus_i` is well formed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Write sum into accumulator |
| sub_i | input | 1 | Subtract bus operand instead of adding |
| bus_i | input | 2*W | Bus operand, two bits per trit |
| acc_o | output | 2*W | Accumulator contents |
| sum_o | output | 2*W | Combinational result word |
| carry_o | output | 2 | Carry trit out of the top digit |
| zero_o | output | 1 | Result word is zero |

## Verification
The hard part is putting an arbitrary value into the accumulator, because the only way to load it is through the adder. The bench keeps its own model of the accumulator. To reach each target value, it drives the bus operand that is congruent to target minus current modulo 3^W, then performs an enabled add. This lets a three-trit instance sweep every accumulator/bus pair in both add and subtract mode. The sweep covers the extreme pairs that give carries of +1 and -1 and the pairs that cancel to zero.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_NEG  = 2'b10;
  localparam trit_t TRIT_ZERO = 2'b00;
  localparam trit_t TRIT_POS  = 2'b01;

  function automatic logic signed [2:0] trit_val(trit_t t);
    case (t)
      TRIT_POS: trit_val = 3'sd1;
      TRIT_NEG: trit_val = -3'sd1;
      default:  trit_val = 3'sd0;
    endcase
  endfunction

  function automatic trit_t trit_flip(trit_t t);
    trit_flip = {t[0], t[1]};
  endfunction
endpackage

// File: rtl/bct_digit_add.sv
module bct_digit_add
  import bct_pkg::*;
(
  input  trit_t a_i,
  input  trit_t b_i,
  input  trit_t c_i,
  output trit_t s_o,
  output trit_t c_o
);
  logic signed [2:0] tot;

  always_comb begin
    tot = trit_val(a_i) + trit_val(b_i) + trit_val(c_i);
    case (tot)
      3'sd3:  begin s_o = TRIT_ZERO; c_o = TRIT_POS;  end
      3'sd2:  begin s_o = TRIT_NEG;  c_o = TRIT_POS;  end
      3'sd1:  begin s_o = TRIT_POS;  c_o = TRIT_ZERO; end
      -3'sd1: begin s_o = TRIT_NEG;  c_o = TRIT_ZERO; end
      -3'sd2: begin s_o = TRIT_POS;  c_o = TRIT_NEG;  end
      -3'sd3: begin s_o = TRIT_ZERO; c_o = TRIT_NEG;  end
      default: begin s_o = TRIT_ZERO; c_o = TRIT_ZERO; end
    endcase
  end
endmodule

// File: rtl/bct_negate.sv
module bct_negate
  import bct_pkg::*;
#(
  parameter int W = 5,
  localparam int TW = 2 * W
) (
  input  logic          en_i,
  input  logic [TW-1:0] word_i,
  output logic [TW-1:0] word_o
);
  for (genvar k = 0; k < W; k++) begin : g_trit
    assign word_o[2*k +: 2] = en_i ? trit_flip(word_i[2*k +: 2]) : word_i[2*k +: 2];
  end
endmodule

// File: rtl/bct_ripple_add.sv
module bct_ripple_add
  import bct_pkg::*;
#(
  parameter int W = 5,
  localparam int TW = 2 * W
) (
  input  logic [TW-1:0] a_i,
  input  logic [TW-1:0] b_i,
  output logic [TW-1:0] s_o,
  output trit_t         c_o
);
  trit_t cy [W+1];

  assign cy[0] = TRIT_ZERO;

  for (genvar k = 0; k < W; k++) begin : g_dig
    bct_digit_add u_dig (
      .a_i (a_i[2*k +: 2]),
      .b_i (b_i[2*k +: 2]),
      .c_i (cy[k]),
      .s_o (s_o[2*k +: 2]),
      .c_o (cy[k+1])
    );
  end

  assign c_o = cy[W];
endmodule

// File: rtl/bct_acc_adder.sv
module bct_acc_adder
  import bct_pkg::*;
#(
  parameter int W = 5,
  localparam int TW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sub_i,
  input  logic [TW-1:0] bus_i,
  output logic [TW-1:0] acc_o,
  output logic [TW-1:0] sum_o,
  output logic [1:0]    carry_o,
  output logic          zero_o
);
  logic [TW-1:0] opb;
  logic [TW-1:0] acc_q;

  bct_negate #(.W(W)) u_neg (
    .en_i   (sub_i),
    .word_i (bus_i),
    .word_o (opb)
  );

  bct_ripple_add #(.W(W)) u_add (
    .a_i (acc_q),
    .b_i (opb),
    .s_o (sum_o),
    .c_o (carry_o)
  );

  // top carry is discarded on write-back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum_o;
  end

  assign acc_o  = acc_q;
  assign zero_o = ~|sum_o;
endmodule

// File: rtl/bct_acc_adder_chk.sv
module bct_acc_adder_chk #(
  parameter int W = 5,
  localparam int TW = 2 * W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          sub_i,
  input logic [TW-1:0] bus_i,
  input logic [TW-1:0] acc_o,
  input logic [TW-1:0] sum_o,
  input logic [1:0]    carry_o,
  input logic          zero_o
);
  function automatic logic has_bad(logic [TW-1:0] w);
    has_bad = 1'b0;
    for (int k = 0; k < W; k++) if (w[2*k +: 2] == 2'b11) has_bad = 1'b1;
  endfunction

  // R6
  acc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> acc_o == $past(sum_o));

  // R6
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_o));

  // R4
  carry_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o != 2'b00 |-> !zero_o);

  // R5
  zero_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && zero_o) |=> acc_o == '0);

  // R8
  legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_bad(bus_i) |-> (!has_bad(sum_o) && !has_bad(acc_o) && carry_o != 2'b11));

  // R7
  always @(posedge clk_i) begin
    if (!rst_ni) reset_clear_chk: assert (acc_o == '0);
  end
endmodule

bind bct_acc_adder bct_acc_adder_chk #(.W(W)) u_chk (.*);

// File: tb/bct_acc_adder_test.sv
module bct_acc_adder_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 3;
  localparam int TW = 2 * W;
  localparam int HALF = 13;
  localparam int MODV = 27;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0;
  logic          sub_i = 1'b0;
  logic [TW-1:0] bus_i = '0;
  logic [TW-1:0] acc_o, sum_o;
  logic [1:0]    carry_o;
  logic          zero_o;

  int checks = 0;
  int fails = 0;
  int model_acc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bct_acc_adder #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .sub_i(sub_i), .bus_i(bus_i),
    .acc_o(acc_o), .sum_o(sum_o), .carry_o(carry_o), .zero_o(zero_o)
  );

  function automatic logic [TW-1:0] to_bct(int v);
    logic [TW-1:0] w = '0;
    int r;
    for (int k = 0; k < W; k++) begin
      r = ((v % 3) + 3) % 3;
      if (r == 1)      begin w[2*k +: 2] = 2'b01; v = (v - 1) / 3; end
      else if (r == 2) begin w[2*k +: 2] = 2'b10; v = (v + 1) / 3; end
      else             begin w[2*k +: 2] = 2'b00; v = v / 3; end
    end
    return w;
  endfunction

  function automatic int trit_int(logic [1:0] t);
    if (t == 2'b01) return 1;
    if (t == 2'b10) return -1;
    if (t == 2'b00) return 0;
    return 99;
  endfunction

  function automatic int from_bct(logic [TW-1:0] w);
    int v = 0;
    for (int k = W - 1; k >= 0; k--) v = v * 3 + trit_int(w[2*k +: 2]);
    return v;
  endfunction

  function automatic int wrap(int s);
    return (((s + HALF) % MODV) + MODV) % MODV - HALF;
  endfunction

  function automatic logic legal(logic [TW-1:0] w);
    for (int k = 0; k < W; k++) if (w[2*k +: 2] == 2'b11) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // load accumulator with target through an enabled add
  task automatic load_acc(input int target);
    @(negedge clk);
    en_i = 1'b1; sub_i = 1'b0; bus_i = to_bct(wrap(target - model_acc));
    @(posedge clk);
    @(negedge clk);
    en_i = 1'b0;
    model_acc = target;
    check(from_bct(acc_o) == target, "R6 load", from_bct(acc_o), target);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int exact, exp_c;
    repeat (2) @(negedge clk);
    // R7 reset state
    check(acc_o == '0, "R7 reset", from_bct(acc_o), 0);
    bus_i = to_bct(5); #1;
    check(from_bct(sum_o) == 5, "R2 during reset", from_bct(sum_o), 5);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 explicit codes: trit0 = 10 means -1
    bus_i = 6'b000010; sub_i = 1'b0; #1;
    check(sum_o == 6'b000010, "R1 minus code", int'(sum_o), 2);
    check(from_bct(sum_o) == -1, "R1 minus value", from_bct(sum_o), -1);
    sub_i = 1'b1; #1;
    check(sum_o == 6'b000001, "R1 negated code", int'(sum_o), 1);
    bus_i = 6'b010000; sub_i = 1'b0; #1;
    check(from_bct(sum_o) == 9, "R1 top weight", from_bct(sum_o), 9);

    // exhaustive sweep R2 R3 R4 R5 R8
    for (int a = -HALF; a <= HALF; a++) begin
      for (int b = -HALF; b <= HALF; b++) begin
        for (int s = 0; s < 2; s++) begin
          load_acc(a);
          bus_i = to_bct(b); sub_i = logic'(s); #1;
          exact = (s != 0) ? a - b : a + b;
          exp_c = (exact > HALF) ? 1 : ((exact < -HALF) ? -1 : 0);
          check(from_bct(sum_o) == wrap(exact), (s != 0) ? "R3 diff" : "R2 sum",
                from_bct(sum_o), wrap(exact));
          check(trit_int(carry_o) == exp_c, "R4 carry", trit_int(carry_o), exp_c);
          check(zero_o == (wrap(exact) == 0), "R5 zero", int'(zero_o), int'(wrap(exact) == 0));
          check(legal(sum_o) && carry_o != 2'b11, "R8 codes", int'(sum_o), 0);
          @(posedge clk);
          @(negedge clk);
          check(from_bct(acc_o) == a, "R6 hold", from_bct(acc_o), a);
        end
      end
    end

    // R6 write-back drops carry: 13 + 13 = 26 -> -1
    load_acc(13);
    bus_i = to_bct(13); sub_i = 1'b0; en_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    en_i = 1'b0;
    check(from_bct(acc_o) == -1, "R6 carry dropped", from_bct(acc_o), -1);
    model_acc = -1;

    // R7 asynchronous clear mid-cycle
    load_acc(7);
    #2 rst_ni = 1'b0; #1;
    check(acc_o == '0, "R7 async clear", from_bct(acc_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    model_acc = 0;
    finish_run();
  end
endmodule